// File: doc/BRIEF.md
# Multiplexed Byte Bus Cycle Generator

This block is the master end of a byte-wide external bus with a 16-bit address. The upper address byte has its own pins. The lower address byte and the data byte share one set of eight lines, used first for address and then for data. The block divides its input clock by four to make a symmetric bus clock, E. E runs at all times, whether or not there is work to do.

An internal client places a read or write request on a level request port. It holds the request until a one-clock acknowledge comes back. The block runs one E cycle for each request, in four input-clock steps:
- First step: the lower address byte goes out on the shared lines, and the address strobe is high while E is low, so that an external latch can capture the byte.
- Second step: the strobe drops and the address stays on the lines.
- E-high half of a write: the write byte is driven on the shared lines.
- E-high half of a read: the lines are released, and the byte is sampled at the clock edge where E falls.

The acknowledge returns that sampled byte.

Top module: `muxbus_master`

## Requirements
- R1: `bus_e` has a period of four clock cycles: two cycles low followed by two cycles high. It toggles on every second rising edge, without interruption, and it is low in the first cycle after reset.
- R2: A bus cycle begins at the rising edge where `bus_e` falls. In the clock that follows, `bus_as` is 1, `bus_e` is 0, `bus_ad_oe` is 1 and `bus_ad_o` equals `req_addr[7:0]`. `bus_as` is high for exactly that one clock.
- R3: In the second clock of a cycle, `bus_as` is 0, `bus_e` is 0, and the shared lines still drive `req_addr[7:0]` with `bus_ad_oe` at 1.
- R4: `bus_ahi` equals `req_addr[15:8]` in all four clocks of the cycle.
- R5: `bus_rw` is 1 throughout a read cycle and 0 throughout a write cycle.
- R6: In both E-high clocks of a write cycle, `bus_ad_oe` is 1 and `bus_ad_o` equals `req_wdata`.
- R7: In both E-high clocks of a read cycle, `bus_ad_oe` is 0. `bus_ad_i` is sampled at the rising edge where `bus_e` falls, and that value is returned on `ack_rdata`. On a write acknowledge, `ack_rdata` is 0.
- R8: `ack` is 1 for exactly one clock, in the clock after the edge that ends the cycle, and it is 0 during the four clocks of the cycle.
- R9: When no request is pending, the E cycle is idle: `bus_as` is 0, `bus_ad_oe` is 0 and `bus_rw` is 1.
- R10: A request presented while the block is idle starts at the next E boundary, which is no more than four clocks away. Each request produces exactly one bus cycle. The E cycle after an acknowledge is always idle.
- R11: While `rst` is high, the outputs are held at these values: `bus_e`=0, `bus_as`=0, `bus_ad_oe`=0, `bus_rw`=1 and `ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four times the E rate |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pending; held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-clock completion pulse |
| ack_rdata | output | 8 | Read byte returned with `ack` |
| bus_e | output | 1 | Bus clock, E |
| bus_as | output | 1 | Address strobe for the low-byte latch |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_ahi | output | 8 | Upper address byte |
| bus_ad_o | output | 8 | Shared address/data lines, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | 8 | Shared lines, incoming value |

## Verification
The assertions assume that the client keeps a request's fields unchanged from the time `req_valid` rises until `ack` arrives, and that it drops `req_valid` as the acknowledge arrives. Otherwise the captured address and data would not match what the client believes it issued. The bench's external memory model latches the address while the strobe is high. It drives `bus_ad_i` only while E is high in a read cycle, so a sample taken at any other time reads back a recognisable filler byte. The stimulus changes request fields only at falling clock edges, and only between an acknowledge and the next assertion of `req_valid`. Random address, direction and data are combined with directed extremes, back-to-back requests and idle gaps.

// File: rtl/muxbus_master.sv
module muxbus_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] ack_rdata,
  output logic              bus_e,
  output logic              bus_as,
  output logic              bus_rw,
  output logic [ADDR_W-DATA_W-1:0] bus_ahi,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_ad_i
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [1:0]        ph;
  logic              busy;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;

  wire at_end = (ph == 2'd3);
  wire start  = at_end && !busy && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= 2'd0;
      busy      <= 1'b0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      ack       <= 1'b0;
      ack_rdata <= '0;
      bus_e     <= 1'b0;
      bus_as    <= 1'b0;
      bus_rw    <= 1'b1;
      bus_ahi   <= '0;
      bus_ad_o  <= '0;
      bus_ad_oe <= 1'b0;
    end else begin
      ph  <= ph + 2'd1;
      ack <= 1'b0;
      case (ph)
        2'd0: bus_as <= 1'b0;
        2'd1: begin
          bus_e <= 1'b1;
          if (busy && wr_q)  bus_ad_o  <= wd_q;
          if (busy && !wr_q) bus_ad_oe <= 1'b0;
        end
        2'd3: begin
          bus_e <= 1'b0;
          if (busy) begin
            ack       <= 1'b1;
            ack_rdata <= wr_q ? '0 : bus_ad_i;
          end
          busy      <= start;
          bus_as    <= start;
          bus_ad_oe <= start;
          bus_rw    <= start ? !req_write : 1'b1;
          if (start) begin
            wr_q     <= req_write;
            wd_q     <= req_wdata;
            bus_ahi  <= req_addr[ADDR_W-1:DATA_W];
            bus_ad_o <= req_addr[DATA_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  e_pace_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_e != $past(bus_e)) |=> (bus_e == $past(bus_e)));

  // R2
  as_elow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> (!bus_e && bus_ad_oe));

  // R2
  as_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_as |=> !bus_as);

  // R4
  ahi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_as |=> $stable(bus_ahi));

  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_e && bus_rw) |-> !bus_ad_oe);

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R8
  ack_elow_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (!bus_e && !$past(bus_as)));

  // R9
  strobe_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_ad_oe) |-> (!bus_as));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = bus_ahi;
endmodule

// File: tb/muxbus_master_bench.sv
`timescale 1ns/1ps
module muxbus_master_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ack, bus_e, bus_as, bus_rw, bus_ad_oe;
  logic [7:0] ack_rdata, bus_ahi, bus_ad_o, bus_ad_i;
  logic [15:0] lat = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  muxbus_master u_muxbus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .ack_rdata(ack_rdata),
    .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw), .bus_ahi(bus_ahi),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i));

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(negedge clk) if (bus_as) lat <= {bus_ahi, bus_ad_o};
  assign bus_ad_i = (bus_e && bus_rw && !bus_ad_oe) ? mem_f(lat) : 8'hC3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(input bit wr, input logic [15:0] a, input logic [7:0] wd);
    int waitc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!bus_as && waitc < 12) begin @(negedge clk); waitc++; end
    chk(waitc <= 4, "R10 start latency", waitc, 4);
    chk(bus_as && !bus_e && bus_ad_oe, "R2 strobe step", {bus_as, bus_e, bus_ad_oe}, 3'b101);
    chk(bus_ad_o == a[7:0], "R2 low address", bus_ad_o, a[7:0]);
    for (int s = 0; s < 4; s++) begin
      if (s > 0) @(negedge clk);
      chk(bus_ahi == a[15:8], "R4 high address", bus_ahi, a[15:8]);
      chk(bus_rw == !wr, "R5 direction", bus_rw, !wr);
      chk(!ack, "R8 no ack mid-cycle", ack, 0);
      if (s == 1) begin
        chk(!bus_as && !bus_e && bus_ad_oe && bus_ad_o == a[7:0], "R3 address hold",
            {bus_as, bus_e, bus_ad_oe, bus_ad_o}, {3'b001, a[7:0]});
      end
      if (s >= 2) begin
        chk(bus_e, "R1 E high half", bus_e, 1);
        if (wr) chk(bus_ad_oe && bus_ad_o == wd, "R6 write data", {bus_ad_oe, bus_ad_o}, {1'b1, wd});
        else    chk(!bus_ad_oe, "R7 lines released", bus_ad_oe, 0);
      end
    end
    @(negedge clk);
    chk(ack && !bus_e, "R8 ack pulse", {ack, bus_e}, 2'b10);
    chk(ack_rdata == (wr ? 8'h00 : mem_f(a)), "R7 read data", ack_rdata, wr ? 8'h00 : mem_f(a));
    req_valid = 1'b0;
    @(negedge clk);
    chk(!ack, "R8 ack single clock", ack, 0);
  endtask

  task automatic idle_chk(input int n);
    logic e1 = bus_e, e2 = bus_e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!bus_as && !bus_ad_oe && bus_rw, "R9 idle levels", {bus_as, bus_ad_oe, bus_rw}, 3'b001);
      chk(!bus_as, "R10 no repeat cycle", bus_as, 0);
      if (i >= 2) chk(bus_e != e2, "R1 E period", bus_e, !e2);
      e2 = e1; e1 = bus_e;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!bus_e && !bus_as && !bus_ad_oe && bus_rw && !ack, "R11 reset state",
        {bus_e, bus_as, bus_ad_oe, bus_rw, ack}, 5'b00010);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_e, "R1 E low after reset", bus_e, 0);
    idle_chk(12);
    txn(1'b1, 16'hFFFF, 8'hFF);
    idle_chk(8);
    txn(1'b0, 16'h0000, 8'h00);
    txn(1'b0, 16'hFFFF, 8'h00);
    txn(1'b1, 16'h0000, 8'h00);
    txn(1'b1, 16'hA55A, 8'h3C);
    txn(1'b0, 16'hA55A, 8'h00);
    idle_chk(8);
    for (int k = 0; k < 60; k++) begin
      txn($urandom_range(0, 1), 16'($urandom), 8'($urandom));
      if ($urandom_range(0, 3) == 0) idle_chk(8);
    end
    idle_chk(8);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule